// File: doc/BRIEF.md
# Digit-Serial GF(2^m) Multiplier

The block multiplies two elements of the binary field GF(2^m), held in polynomial basis, and reduces the product by a fixed irreducible polynomial given as a parameter. The second operand is consumed one 4-bit digit per clock, starting with the most significant digit. In each step the running sum is multiplied by x^4 and reduced. The first operand, multiplied by the current digit and reduced, is then XORed in. A full product therefore takes ceil(m/4) clocks. A bit-serial unit would need m.

A caller raises `start` for one cycle with both operands present. A multiplication keeps `busy` high while its digits are processed. Then `done` pulses for one cycle and `result` holds the product until the next operation finishes. If `op_add` is set with `start`, the block performs field addition (bitwise XOR) instead and completes on the next clock. The default field is GF(2^191) with the trinomial x^191 + x^9 + 1. The serial operand is padded to 192 bits, that is 48 digits.

Top module: `gf_digit_mul`

## Requirements
- R1: While reset is held low and right after it, `busy` and `done` are 0 and `result` is all zeros.
- R2: A multiplication returns a·b mod f(x), where bit i of an operand is the coefficient of x^i and f defaults to x^191 + x^9 + 1. For example, x^190 · x^2 gives x^10 + x.
- R3: The clock edge that accepts a multiplication start raises `busy`. `done` rises exactly ceil(m/4) edges later (48 by default), at the same edge where `busy` falls, and stays high for that one cycle only.
- R4: `result` changes only at an edge that raises `done`. Operand changes outside an accepted start leave it untouched.
- R5: A `start` that arrives while `busy` is high is ignored. The running product, its timing and its result are unaffected.
- R6: With `op_add` = 1 on an accepted start, `result` becomes a XOR b and `done` pulses at the next edge, without `busy` ever rising.
- R7: A `start` presented in the cycle where `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_add | input | 1 | Selects field addition (1) or multiplication (0) at start |
| opnd_a | input | M | Parallel operand a |
| opnd_b | input | M | Serial operand b, consumed 4 bits per clock, MSB digit first |
| busy | output | 1 | High while a multiplication is running |
| done | output | 1 | One-cycle completion pulse |
| result | output | M | Last finished product or sum |

## Verification
Two of the block's functions can meet in one cycle. One is the completion of a product. The other is the acceptance of the next start, which the bench provokes by raising `start` in the very cycle that shows `done` high. That new operation must begin cleanly: `busy` high and `done` low one cycle later, and the right product after a full digit count. The bench also drives a start in the middle of a run. It checks that this start leaves both the cycle count and the product of the running job unchanged, comparing every product with a bit-at-a-time Horner reference.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;
  localparam int DIGIT_W = 4;

  function automatic int digit_count(input int width);
    return (width + DIGIT_W - 1) / DIGIT_W;
  endfunction
endpackage

// File: rtl/gf_mul_step.sv
module gf_mul_step
  import gf_mul_pkg::*;
#(
  parameter int M = 191,
  parameter logic [M-1:0] POLY = {{(M-10){1'b0}}, 10'h201}
) (
  input  logic [M-1:0]       acc_in,
  input  logic [M-1:0]       mcand,
  input  logic [DIGIT_W-1:0] digit,
  output logic [M-1:0]       acc_out
);
  // multiply by x and fold the overflow term back with the low polynomial terms
  function automatic logic [M-1:0] times_x(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? POLY : '0);
  endfunction

  logic [M-1:0] shifted [DIGIT_W+1];
  logic [M-1:0] pp      [DIGIT_W];
  logic [M-1:0] sel     [DIGIT_W];

  assign shifted[0] = acc_in;
  assign pp[0]      = mcand;

  for (genvar k = 1; k <= DIGIT_W; k++) begin : g_shift
    assign shifted[k] = times_x(shifted[k-1]);
  end

  for (genvar k = 1; k < DIGIT_W; k++) begin : g_pp
    assign pp[k] = times_x(pp[k-1]);
  end

  for (genvar k = 0; k < DIGIT_W; k++) begin : g_sel
    if (k == 0) begin : g_first
      assign sel[k] = digit[k] ? pp[k] : '0;
    end else begin : g_rest
      assign sel[k] = sel[k-1] ^ (digit[k] ? pp[k] : '0);
    end
  end

  assign acc_out = shifted[DIGIT_W] ^ sel[DIGIT_W-1];
endmodule

// File: rtl/gf_mul_seq.sv
module gf_mul_seq #(
  parameter int ND = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_add,
  output logic busy,
  output logic load,
  output logic add_go,
  output logic last,
  output logic done
);
  localparam int CW = $clog2(ND + 1);

  logic          busy_q, done_q;
  logic [CW-1:0] cnt_q;

  assign load   = start && !busy_q && !op_add;
  assign add_go = start && !busy_q && op_add;
  assign last   = busy_q && (cnt_q == '0);
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last || add_go;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(ND - 1);
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(ND)));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  p_fall_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  p_add_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    add_go |=> (done_q && !busy_q));
endmodule

// File: rtl/gf_digit_mul.sv
module gf_digit_mul
  import gf_mul_pkg::*;
#(
  parameter int M = 191,
  parameter logic [M-1:0] POLY = {{(M-10){1'b0}}, 10'h201}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_add,
  input  logic [M-1:0] opnd_a,
  input  logic [M-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] result
);
  localparam int ND = digit_count(M);
  localparam int BW = ND * DIGIT_W;

  logic [M-1:0]  a_q, acc_q, res_q, acc_nx;
  logic [BW-1:0] bsh_q;
  logic          load, add_go, last;

  gf_mul_seq #(.ND(ND)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_add(op_add),
    .busy(busy), .load(load), .add_go(add_go), .last(last), .done(done)
  );

  gf_mul_step #(.M(M), .POLY(POLY)) step_i (
    .acc_in(acc_q), .mcand(a_q), .digit(bsh_q[BW-1 -: DIGIT_W]), .acc_out(acc_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      acc_q <= '0;
      bsh_q <= '0;
      res_q <= '0;
    end else begin
      if (load) begin
        a_q   <= opnd_a;
        bsh_q <= BW'(opnd_b);
        acc_q <= '0;
      end else if (busy) begin
        acc_q <= acc_nx;
        bsh_q <= bsh_q << DIGIT_W;
      end
      if (last)        res_q <= acc_nx;
      else if (add_go) res_q <= opnd_a ^ opnd_b;
    end
  end

  assign result = res_q;

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(res_q) |-> done);

  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && !done));
endmodule

// File: tb/gf_digit_mul_tb.sv
module gf_digit_mul_tb_top;
  localparam int M       = 191;
  localparam int ND      = 48;
  localparam int CLK_PER = 10;
  localparam logic [M-1:0] POLY = M'(10'h201);
  localparam int NV = 6;

  localparam logic [M-1:0] VA [NV] = '{
    M'(1), M'(0), {1'b1, {(M-1){1'b0}}}, {M{1'b1}}, M'({6{32'h9E3779B9}}), M'(192'hF00D)};
  localparam logic [M-1:0] VB [NV] = '{
    M'(1), M'(2), M'(2), {M{1'b1}}, M'({6{32'h7F4A7C15}}), {1'b1, {(M-1){1'b0}}}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_add = 1'b0;
  logic [M-1:0] opnd_a = '0, opnd_b = '0;
  logic busy, done;
  logic [M-1:0] result;
  int compared = 0, mismatched = 0, cyc_ctr = 0;

  always #(CLK_PER/2) clk = ~clk;

  gf_digit_mul #(.M(M), .POLY(POLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_add(op_add),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done), .result(result)
  );

  // bit-at-a-time Horner reference
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY : '0);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [M-1:0] a, input logic [M-1:0] b, input logic add, output int cyc);
    opnd_a = a; opnd_b = b; op_add = add; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_add = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  always @(posedge clk) begin
    cyc_ctr++;
    if (cyc_ctr > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog R3 actual=%0d expected<=100000", cyc_ctr);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [M-1:0] hold;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", M'(busy), '0);
    chk("R1 done in reset", M'(done), '0);
    chk("R1 result in reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 result after reset", result, '0);

    // table of products
    for (int v = 0; v < NV; v++) begin
      run_op(VA[v], VB[v], 1'b0, cyc);
      chk("R3 cycles to done", M'(cyc), M'(ND));
      chk("R2 product", result, ref_mul(VA[v], VB[v]));
      @(negedge clk);
      chk("R3 done single cycle", M'(done), '0);
    end

    // reduction wraps x^192 to x^10 + x
    run_op({1'b1, {(M-1){1'b0}}}, M'(4), 1'b0, cyc);
    chk("R2 x^190*x^2", result, M'(11'h402));

    // R4: result held while operands wiggle
    hold = result;
    for (int k = 0; k < 5; k++) begin
      opnd_a = ~opnd_a; opnd_b = opnd_b ^ M'(k + 7);
      @(negedge clk);
    end
    chk("R4 result held", result, hold);

    // R5: start while busy
    opnd_a = VA[4]; opnd_b = VB[3]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    opnd_a = VA[3]; opnd_b = VB[4]; op_add = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_add = 1'b0;
    chk("R5 still busy", M'(busy), M'(1));
    cyc = 11;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R5 cycles unchanged", M'(cyc), M'(ND));
    chk("R5 product unchanged", result, ref_mul(VA[4], VB[3]));

    // R6: addition
    run_op(VA[4], VB[4], 1'b1, cyc);
    chk("R6 add cycles", M'(cyc), '0);
    chk("R6 add busy", M'(busy), '0);
    chk("R6 add result", result, VA[4] ^ VB[4]);

    // R7: start in the done cycle
    run_op(VA[5], VB[2], 1'b0, cyc);
    chk("R7 first product", result, ref_mul(VA[5], VB[2]));
    opnd_a = VA[4]; opnd_b = VB[5]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after back-to-back", M'(busy), M'(1));
    chk("R7 done cleared", M'(done), '0);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk("R7 cycles", M'(cyc), M'(ND));
    chk("R7 second product", result, ref_mul(VA[4], VB[5]));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule